// File: doc/BRIEF.md
# I2C Master Clock Phase Generator

This block produces the clock line of an I2C master. It drives an open-drain enable for SCL and sets the time the line stays low and the time it stays high from two programmable counts. The counts are in count-clock ticks, and a configuration input selects whether one tick is one or two system clocks. The low phase is timed from the clock in which the block starts pulling the line down. The high phase is timed only after the synchronized SCL input has been seen high, so rise time and slave clock stretching lengthen the period rather than shorten the high time.

The byte engine controls the clock with one run request. While the request is asserted, the clock keeps cycling. When the request is dropped at the end of a low phase, SCL stays pulled low until the request returns. When the request is dropped at the end of a high phase, SCL is released and stays parked high. Two one-clock strobes tell the byte engine when to change SDA (at the middle of the low phase) and when to sample it (in the first clock of the high phase). Each count is nine bits wide. The ninth bit of each count arrives on a separate two-bit input. A build parameter selects a variant that ignores these ninth bits and limits both counts to 255.

Top module: `scl_period_gen`

## Requirements
- R1: With run requested, each low phase lasts exactly Nl*D clocks of sclDriveLow=1 and each high phase lasts exactly Nh*D clocks. Here Nl and Nh are the effective low and high counts, and D is the tick length in clocks.
- R2: D is 1 when divByTwo=0 and 2 when divByTwo=1.
- R3: The low phase is timed from the first clock of sclDriveLow=1. The level of sclIn during the low phase does not change its length.
- R4: After release, the high phase starts one clock after the synchronized sclIn (SYNC_STAGES flops, reset to 1) reads high, having read low since the low phase began. While a slave holds sclIn low, the high phase does not start and no sample strobe is given.
- R5: The low count is {countMsbs[1], lowCount} and the high count is {countMsbs[0], highCount}, both 9 bits.
- R6: With EXT_EN=0, countMsbs has no effect and both counts are limited to 255.
- R7: A count of zero acts as a count of one tick.
- R8: sdaChangeStb is high for exactly one clock in each low phase, on tick number floor((Nl-1)/2), counted from 0.
- R9: sdaSampleStb is high for exactly one clock, which is the first clock of each high phase.
- R10: If runReq=0 when a low phase ends, SCL stays driven low until runReq=1. If runReq=0 when a high phase ends, SCL is released and parked. When parked, runReq=1 starts driving low on the next clock.
- R11: During and right after reset, SCL is released and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| runReq | input | 1 | Run request from the byte engine |
| divByTwo | input | 1 | 1: one tick is two clocks; 0: one clock |
| lowCount | input | LSB_W | Low-phase count, lower bits |
| highCount | input | LSB_W | High-phase count, lower bits |
| countMsbs | input | 2 | [1] = ninth bit of low count, [0] = ninth bit of high count |
| sclIn | input | 1 | Sensed SCL line level |
| sclDriveLow | output | 1 | 1 pulls SCL low (open-drain enable) |
| sdaChangeStb | output | 1 | One-clock strobe: change SDA now |
| sdaSampleStb | output | 1 | One-clock strobe: sample SDA now |

## Verification
The hardest situation to reach from the ports is a released line that a slave keeps low. The block must then wait with its counter parked, and it must start the high phase from the moment the synchronizer sees the rise, not from the release. The bench models the bus as a wired AND of the block's drive and a stretch signal of its own. It asserts that stretch while the reference model is waiting for the line to rise, and again across a low phase. A run at 9-bit counts is placed after a stretch of cycle-by-cycle comparison against a second instance built without the extension bits and fed all-ones ninth bits.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

  typedef enum logic [2:0] {
    PH_IDLE      = 3'd0,
    PH_LOW       = 3'd1,
    PH_HOLD      = 3'd2,
    PH_WAIT_HIGH = 3'd3,
    PH_HIGH      = 3'd4
  } phase_e;

  // control -> datapath
  typedef struct packed {
    logic restart;    // clear prescaler and tick counter
    logic countHigh;  // select the high-phase limit
  } dpCtl_t;

  // datapath -> control
  typedef struct packed {
    logic phaseDone;  // last tick of the current phase
    logic midTick;    // tick at the midpoint of the phase
    logic sclHigh;    // synchronized line level
  } dpStat_t;

endpackage

// File: rtl/scl_gen_dp.sv
module scl_gen_dp
  import scl_gen_pkg::*;
#(
  parameter int LSB_W       = 8,
  parameter int EXT_EN      = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtl_t           ctl,
  input  logic             divByTwo,
  input  logic [LSB_W-1:0] lowCount,
  input  logic [LSB_W-1:0] highCount,
  input  logic [1:0]       countMsbs,
  input  logic             sclIn,
  output dpStat_t          stat
);

  localparam int   CNT_W   = LSB_W + 1;
  localparam logic EXT_BIT = (EXT_EN != 0);

  logic [CNT_W-1:0] lowRaw, highRaw, lowLim, highLim, lim, midPt, cnt;
  logic             pre, tick;
  logic [SYNC_STAGES-1:0] syncQ;

  // ninth bits are masked off in the narrow variant
  assign lowRaw  = {countMsbs[1] & EXT_BIT, lowCount};
  assign highRaw = {countMsbs[0] & EXT_BIT, highCount};

  // a zero count behaves as one tick
  assign lowLim  = (lowRaw  == '0) ? CNT_W'(1) : lowRaw;
  assign highLim = (highRaw == '0) ? CNT_W'(1) : highRaw;

  assign lim   = ctl.countHigh ? highLim : lowLim;
  assign midPt = (lim - 1'b1) >> 1;
  assign tick  = ~divByTwo | pre;

  always_ff @(posedge clk) begin
    if (!rstN || ctl.restart) begin
      pre <= 1'b0;
      cnt <= '0;
    end else begin
      pre <= divByTwo & ~pre;
      if (tick) cnt <= cnt + 1'b1;
    end
  end

  // line synchronizer, idle level high
  genvar gi;
  generate
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : gSync
      if (gi == 0) begin : gFirst
        always_ff @(posedge clk) begin
          if (!rstN) syncQ[0] <= 1'b1;
          else       syncQ[0] <= sclIn;
        end
      end else begin : gNext
        always_ff @(posedge clk) begin
          if (!rstN) syncQ[gi] <= 1'b1;
          else       syncQ[gi] <= syncQ[gi-1];
        end
      end
    end
  endgenerate

  assign stat.phaseDone = tick && (cnt == lim - 1'b1);
  assign stat.midTick   = tick && (cnt == midPt);
  assign stat.sclHigh   = syncQ[SYNC_STAGES-1];

  // R2: with two clocks per tick, a tick is never followed by another
  a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rstN)
    (divByTwo && tick && !ctl.restart) |=> (!tick || !divByTwo));

  // R1: the counter stays below the active limit while counting
  a_r1_cnt_bound: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.restart && $stable(lim)) |-> (cnt < lim));

endmodule

// File: rtl/scl_gen_ctrl.sv
module scl_gen_ctrl
  import scl_gen_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    runReq,
  input  dpStat_t stat,
  output dpCtl_t  ctl,
  output logic    sclDriveLow,
  output logic    sdaChangeStb,
  output logic    sdaSampleStb
);

  phase_e state, stateNxt;
  logic   seenLow, highFirst, goHigh;

  assign goHigh = (state == PH_WAIT_HIGH) && seenLow && stat.sclHigh;

  always_comb begin
    stateNxt = state;
    unique case (state)
      PH_IDLE:      if (runReq) stateNxt = PH_LOW;
      PH_LOW:       if (stat.phaseDone) stateNxt = runReq ? PH_WAIT_HIGH : PH_HOLD;
      PH_HOLD:      if (runReq) stateNxt = PH_WAIT_HIGH;
      PH_WAIT_HIGH: if (goHigh) stateNxt = PH_HIGH;
      PH_HIGH:      if (stat.phaseDone) stateNxt = runReq ? PH_LOW : PH_IDLE;
      default:      stateNxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= PH_IDLE;
      seenLow   <= 1'b0;
      highFirst <= 1'b0;
    end else begin
      state     <= stateNxt;
      highFirst <= goHigh;
      if (state == PH_IDLE || state == PH_HIGH) seenLow <= 1'b0;
      else if (!stat.sclHigh)                   seenLow <= 1'b1;
    end
  end

  assign ctl.restart   = !(state == PH_LOW || state == PH_HIGH) || stat.phaseDone;
  assign ctl.countHigh = (state == PH_HIGH);

  assign sclDriveLow  = (state == PH_LOW) || (state == PH_HOLD);
  assign sdaChangeStb = (state == PH_LOW) && stat.midTick;
  assign sdaSampleStb = highFirst;

  // R3: the line stays pulled low until the low count expires
  a_r3_low_held: assert property (@(posedge clk) disable iff (!rstN)
    (state == PH_LOW && !stat.phaseDone) |=> sclDriveLow);

  // R4: no high phase while the sensed line is low
  a_r4_wait_line: assert property (@(posedge clk) disable iff (!rstN)
    (state == PH_WAIT_HIGH && !stat.sclHigh) |=> (state != PH_HIGH));

  // R9: sampling only happens with the line released
  a_r9_sample_released: assert property (@(posedge clk) disable iff (!rstN)
    sdaSampleStb |-> !sclDriveLow);

  // R8: change and sample strobes never coincide
  a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
    !(sdaChangeStb && sdaSampleStb));

  // R10: a hold keeps the line low while the request is absent
  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    (state == PH_HOLD && !runReq) |=> sclDriveLow);

endmodule

// File: rtl/scl_period_gen.sv
module scl_period_gen
  import scl_gen_pkg::*;
#(
  parameter int LSB_W       = 8,
  parameter int EXT_EN      = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             runReq,
  input  logic             divByTwo,
  input  logic [LSB_W-1:0] lowCount,
  input  logic [LSB_W-1:0] highCount,
  input  logic [1:0]       countMsbs,
  input  logic             sclIn,
  output logic             sclDriveLow,
  output logic             sdaChangeStb,
  output logic             sdaSampleStb
);

  dpCtl_t  ctl;
  dpStat_t stat;

  scl_gen_ctrl uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .runReq       (runReq),
    .stat         (stat),
    .ctl          (ctl),
    .sclDriveLow  (sclDriveLow),
    .sdaChangeStb (sdaChangeStb),
    .sdaSampleStb (sdaSampleStb)
  );

  scl_gen_dp #(
    .LSB_W       (LSB_W),
    .EXT_EN      (EXT_EN),
    .SYNC_STAGES (SYNC_STAGES)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .divByTwo  (divByTwo),
    .lowCount  (lowCount),
    .highCount (highCount),
    .countMsbs (countMsbs),
    .sclIn     (sclIn),
    .stat      (stat)
  );

  // R11: released and quiet in the first cycle after reset
  a_r11_reset_quiet: assert property (@(posedge clk)
    $rose(rstN) |-> (!sclDriveLow && !sdaChangeStb && !sdaSampleStb));

endmodule

// File: tb/tb_scl_period_gen.sv
module tb_scl_period_gen;

  localparam int CLK_PERIOD = 10;
  localparam int SYNC       = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic runReq = 1'b0, divByTwo = 1'b0, stretch = 1'b0;
  logic [7:0] lowCount = 8'd0, highCount = 8'd0;
  logic [1:0] countMsbs = 2'b00;
  logic sclIn, sclDriveLow, sdaChangeStb, sdaSampleStb;
  logic sclInB, driveB, changeB, sampleB;

  always #(CLK_PERIOD/2) clk = ~clk;

  // wired-AND bus: the block or a slave can pull the line low
  assign sclIn  = !sclDriveLow && !stretch;
  assign sclInB = !driveB && !stretch;

  scl_period_gen #(.LSB_W(8), .EXT_EN(1), .SYNC_STAGES(SYNC)) dut (
    .clk(clk), .rstN(rstN), .runReq(runReq), .divByTwo(divByTwo),
    .lowCount(lowCount), .highCount(highCount), .countMsbs(countMsbs),
    .sclIn(sclIn), .sclDriveLow(sclDriveLow),
    .sdaChangeStb(sdaChangeStb), .sdaSampleStb(sdaSampleStb));

  // narrow variant fed all-ones ninth bits (R6)
  scl_period_gen #(.LSB_W(8), .EXT_EN(0), .SYNC_STAGES(SYNC)) dutNoExt (
    .clk(clk), .rstN(rstN), .runReq(runReq), .divByTwo(divByTwo),
    .lowCount(lowCount), .highCount(highCount), .countMsbs(2'b11),
    .sclIn(sclInB), .sclDriveLow(driveB),
    .sdaChangeStb(changeB), .sdaSampleStb(sampleB));

  int nCmp = 0, nBad = 0, cyc = 0;
  bit done = 0, cmpOn = 0, cmpNoExt = 0;
  string curReq = "R11";

  // ---------------- reference model ----------------
  int mSt = 0;        // 0 parked, 1 low, 2 held low, 3 waiting for rise, 4 high
  int mEl = 0;        // clock index inside the current timed phase
  bit mSeen = 0, mFirst = 0;
  bit [SYNC-1:0] mSync = '1;

  function automatic int effCount(input logic msb, input logic [7:0] lsb);
    int v;
    v = (msb ? 256 : 0) + int'(lsb);
    return (v == 0) ? 1 : v;
  endfunction

  always @(posedge clk) begin
    int d, nL, nH, oldSt;
    bit hi, oldSeen;
    if (!rstN) begin
      mSt = 0; mEl = 0; mSeen = 0; mFirst = 0; mSync = '1;
    end else begin
      hi = mSync[SYNC-1];
      mSync = {mSync[SYNC-2:0], sclIn};
      d  = divByTwo ? 2 : 1;
      nL = effCount(countMsbs[1], lowCount);
      nH = effCount(countMsbs[0], highCount);
      oldSt = mSt; oldSeen = mSeen;
      mFirst = 0;
      if (oldSt == 0 || oldSt == 4) mSeen = 0;
      else if (!hi) mSeen = 1;
      case (oldSt)
        0: if (runReq) begin mSt = 1; mEl = 0; end
        1: if (mEl == nL*d - 1) begin mSt = runReq ? 3 : 2; mEl = 0; end
           else mEl++;
        2: if (runReq) mSt = 3;
        3: if (oldSeen && hi) begin mSt = 4; mEl = 0; mFirst = 1; end
        4: if (mEl == nH*d - 1) begin mSt = runReq ? 1 : 0; mEl = 0; end
           else mEl++;
        default: mSt = 0;
      endcase
    end
  end

  function automatic bit expChange();
    int d, nL;
    d  = divByTwo ? 2 : 1;
    nL = effCount(countMsbs[1], lowCount);
    return (mSt == 1) && (mEl == (((nL - 1) / 2) + 1) * d - 1);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison away from the clock edge
  always @(negedge clk) begin
    if (cmpOn && !done) begin
      check(sclDriveLow == (mSt == 1 || mSt == 2), {"R1 scenario ", curReq},
            "sclDriveLow", sclDriveLow, (mSt == 1 || mSt == 2));
      check(sdaChangeStb == expChange(), {"R8 scenario ", curReq},
            "sdaChangeStb", sdaChangeStb, expChange());
      check(sdaSampleStb == mFirst, {"R9 scenario ", curReq},
            "sdaSampleStb", sdaSampleStb, mFirst);
      if (cmpNoExt)
        check({driveB, changeB, sampleB} == {sclDriveLow, sdaChangeStb, sdaSampleStb},
              "R6", "narrow variant outputs",
              {driveB, changeB, sampleB}, {sclDriveLow, sdaChangeStb, sdaSampleStb});
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 60000 && !done) begin
      done = 1;
      nCmp++; nBad++;
      $display("FAIL watchdog: actual %0d cycles expected < 60000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic cfg(input int lo, input int hi, input logic [1:0] msb, input logic dv);
    lowCount = 8'(lo); highCount = 8'(hi); countMsbs = msb; divByTwo = dv;
  endtask

  // bring the clock to the parked state
  task automatic park();
    runReq = 1'b0;
    while (mSt != 0 && mSt != 2) step(1);
    if (mSt == 2) begin
      runReq = 1'b1;
      while (mSt != 3) step(1);
      runReq = 1'b0;
      while (mSt != 0) step(1);
    end
    step(3);
  endtask

  task automatic runCycles(input int n);
    runReq = 1'b1;
    step(n);
    park();
  endtask

  initial begin
    // R11: reset state
    step(4);
    check(!sclDriveLow, "R11", "drive in reset", sclDriveLow, 0);
    check(!sdaChangeStb && !sdaSampleStb, "R11", "strobes in reset",
          {sdaChangeStb, sdaSampleStb}, 0);
    rstN = 1'b1;
    step(1);
    check(!sclDriveLow, "R11", "drive after reset", sclDriveLow, 0);
    cmpOn = 1; cmpNoExt = 1;

    // R1: basic periods, one clock per tick
    curReq = "R1"; cfg(5, 3, 2'b00, 1'b0); runCycles(60);
    // R2: two clocks per tick
    curReq = "R2"; cfg(4, 2, 2'b00, 1'b1); runCycles(60);
    // R7: zero counts act as one tick
    curReq = "R7"; cfg(0, 0, 2'b00, 1'b0); runCycles(20);
    cfg(0, 0, 2'b00, 1'b1); runCycles(24);
    // R8: midpoint of odd and even counts
    curReq = "R8"; cfg(1, 6, 2'b00, 1'b0); runCycles(30);
    cfg(2, 1, 2'b00, 1'b1); runCycles(30);
    cfg(7, 2, 2'b00, 1'b0); runCycles(40);

    // R4: slave stretches the released line
    curReq = "R4"; cfg(3, 4, 2'b00, 1'b0);
    runReq = 1'b1;
    while (mSt != 3) step(1);
    stretch = 1'b1;
    for (int i = 0; i < 15; i++) begin
      step(1);
      check(!sdaSampleStb && !sclDriveLow, "R4", "stalled while stretched",
            {sdaSampleStb, sclDriveLow}, 0);
    end
    stretch = 1'b0;
    step(20);
    park();

    // R3: external low during the low phase does not lengthen it
    curReq = "R3"; cfg(20, 3, 2'b00, 1'b0);
    runReq = 1'b1;
    while (mSt != 1) step(1);
    stretch = 1'b1; step(6); stretch = 1'b0;
    step(60);
    park();

    // R10: hold low, then park high
    curReq = "R10"; cfg(4, 4, 2'b00, 1'b0);
    runReq = 1'b1;
    while (mSt != 1) step(1);
    runReq = 1'b0;
    step(8);
    for (int i = 0; i < 12; i++) begin
      step(1);
      check(sclDriveLow, "R10", "held low without request", sclDriveLow, 1);
    end
    runReq = 1'b1;
    while (mSt != 4) step(1);
    runReq = 1'b0;
    step(8);
    for (int i = 0; i < 8; i++) begin
      step(1);
      check(!sclDriveLow && !sdaSampleStb, "R10", "parked released",
            {sclDriveLow, sdaSampleStb}, 0);
    end
    runReq = 1'b1; step(1);
    check(sclDriveLow, "R10", "restart from park", sclDriveLow, 1);
    park();

    // R5: nine-bit counts (narrow variant no longer compared)
    cmpNoExt = 0;
    curReq = "R5"; cfg(5, 2, 2'b11, 1'b0); runCycles(1100);
    cfg(0, 0, 2'b10, 1'b0); runCycles(300);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule